// File: doc/BRIEF.md
# Analog Output Load Detection Controller

This block decides whether a display or TV is attached to an analog video output by checking whether each output loop is loaded. A loaded loop draws current, so its digitized sense level drops. The block compares each sense level against a programmable threshold and reports which loops are closed. A small sequencer turns those loop results into a connected or not-connected verdict for the connector type in use.

Three 32-bit registers are reachable through a simple write/read port:

- A test-data word holds an enable bit and three 10-bit thresholds.
- A test-control word returns the latched loop results above 28 plain control bits.
- An output word carries a 4-bit output-mode field.

A detection run begins with a start pulse. Each pass waits a programmable number of settle cycles and then samples the comparators.

- For the three-loop colour connector there is one pass. A strict or lenient policy decides the verdict.
- For the TV connectors there are two passes: the first with the mode field forced to 3, the second with it forced to 7. The verdict is connected if either pass succeeds.

Top module: `ld_detect`

## Requirements
- R1: After reset the test-data register (address 0) reads 0x94050140. The test-control register (address 1) and the output register (address 2) read 0, and `connected_o`, `busy_o` and `done_o` are low.
- R2: In the test-data word, bit 31 enables testing and drives `test_en_o`. The channel thresholds are ch2 in bits 29:20, ch1 in bits 19:10 and ch0 in bits 9:0. Channel i senses on `sense_i[10*i+9:10*i]`.
- R3: A loop is closed when its sensed level is strictly below its threshold. A level equal to the threshold is open. The closed flags are latched at each sampling point. In the test-control word, bit 29 reports ch0, bit 30 reports ch1 and bit 31 reports ch2 (1 means closed).
- R4: Test-control bit 28 reads 1 only when bits 31:29 all read 1.
- R5: Test-control bits 27:0 are read/write. Writes to bits 31:28 have no effect on them.
- R6: While the enable bit is clear, the result bits 31:28 read 0 and every run ends not connected.
- R7: The connector type is selected by `conn_type_i`: 0 is the three-loop colour connector (RGB), 1 is the two-loop luma/chroma connector, and 2 and 3 are the single-loop composite connector. For RGB (`conn_type_i`=0), with `lenient_i`=0 all three loops must be closed. With `lenient_i`=1 any one closed loop is enough.
- R8: The luma/chroma type (`conn_type_i`=1) uses ch0 and ch1: strict needs both closed, lenient needs either. The composite types (2 and 3) use ch0 only. ch2 never affects a verdict for these types.
- R9: For `conn_type_i` 1 to 3, `mode_nibble_o` reads 3 during the first pass and 7 during the second. The verdict is connected if either pass meets the rule.
- R10: Outside TV passes, `mode_nibble_o` equals output-register bits 7:4. An RGB run leaves it unchanged, and after any run it returns to the register value.
- R11: With settle value S, `done_o` pulses for one cycle. For RGB it comes S+2 rising edges after the edge that accepts the start, and for the TV types 2S+4 edges after it. `connected_o` holds the verdict from that point.
- R12: A start pulse while `busy_o` is high is ignored and causes no further run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 test-data, 1 test-control, 2 output) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| start_i | input | 1 | Start a detection run |
| conn_type_i | input | 2 | Connector type |
| lenient_i | input | 1 | 1 selects the lenient policy |
| settle_i | input | SETTLE_W | Settle cycles before each sample |
| sense_i | input | 30 | Three 10-bit sensed levels |
| mode_nibble_o | output | 4 | Output-mode field driven to the output stage |
| test_en_o | output | 1 | Test enable to the analog front end |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| connected_o | output | 1 | Verdict of the last run |

## Verification
Several internal faults show up at `done_o` within one run:

- A miscounted settle counter moves `done_o` off its expected edge.
- A lost second TV pass does the same, and it also drops mode value 7 from the set of values seen on `mode_nibble_o`.
- A wrong comparator polarity or channel mapping shows in the latched result bits on the same `done_o`, as does a wrong policy in `connected_o`. The threshold-equal case catches an off-by-one in the comparison.

An enable bit not applied to the results shows at the next test-control read. A restart that is not blocked shows as an extra `done_o` within a few settle periods.

// File: rtl/ld_pkg.sv
package ld_pkg;
  localparam int NCH   = 3;
  localparam int LVL_W = 10;
  localparam int DW    = 32;
  localparam int EN_BIT  = 31;
  localparam int RES_LSB = 28;
  localparam int NIB_LSB = 4;

  localparam logic [1:0] A_TDATA = 2'd0;
  localparam logic [1:0] A_TCTRL = 2'd1;
  localparam logic [1:0] A_OUT   = 2'd2;

  localparam logic [3:0] NIB_PASS0 = 4'd3;
  localparam logic [3:0] NIB_PASS1 = 4'd7;

  typedef enum logic [1:0] {
    CONN_RGB  = 2'd0,
    CONN_LC   = 2'd1,
    CONN_COMP = 2'd2,
    CONN_ALT  = 2'd3
  } conn_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SETTLE, ST_SAMPLE, ST_DONE
  } st_e;
endpackage

// File: rtl/ld_regs.sv
module ld_regs
  import ld_pkg::*;
#(
  parameter logic [31:0] TDATA_RST = 32'h9405_0140
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [1:0]           addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 sample_i,
  input  logic [NCH-1:0]       closed_i,
  output logic [DW-1:0]        rdata_o,
  output logic [NCH*LVL_W-1:0] thr_o,
  output logic                 test_en_o,
  output logic [3:0]           out_nib_o
);
  logic [DW-1:0]      tdata_q, out_q;
  logic [RES_LSB-1:0] ctrl_q;
  logic [NCH-1:0]     res_q, res_vis;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdata_q <= TDATA_RST;
      out_q   <= '0;
      ctrl_q  <= '0;
      res_q   <= '0;
    end else begin
      if (wr_en_i) begin
        case (addr_i)
          A_TDATA: tdata_q <= wdata_i;
          A_TCTRL: ctrl_q  <= wdata_i[RES_LSB-1:0];
          A_OUT:   out_q   <= wdata_i;
          default: ;
        endcase
      end
      if (sample_i) res_q <= closed_i;
    end
  end

  assign test_en_o = tdata_q[EN_BIT];
  assign thr_o     = tdata_q[NCH*LVL_W-1:0];
  assign out_nib_o = out_q[NIB_LSB +: 4];
  // results are hidden whenever testing is disabled
  assign res_vis   = test_en_o ? res_q : '0;

  always_comb begin
    case (addr_i)
      A_TDATA: rdata_o = tdata_q;
      A_TCTRL: rdata_o = {res_vis, &res_vis, ctrl_q};
      A_OUT:   rdata_o = out_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ld_compare.sv
module ld_compare
  import ld_pkg::*;
(
  input  logic                 en_i,
  input  logic [NCH*LVL_W-1:0] sense_i,
  input  logic [NCH*LVL_W-1:0] thr_i,
  output logic [NCH-1:0]       closed_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    // loaded loop pulls the level below threshold
    assign closed_o[g] = en_i && (sense_i[g*LVL_W +: LVL_W] < thr_i[g*LVL_W +: LVL_W]);
  end
endmodule

// File: rtl/ld_seq.sv
module ld_seq
  import ld_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          type_i,
  input  logic                lenient_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [NCH-1:0]      closed_i,
  input  logic [3:0]          reg_nib_i,
  output logic                sample_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                connected_o,
  output logic                tv_o,
  output logic [3:0]          nib_o
);
  st_e                 st_q;
  conn_e               type_q;
  logic [SETTLE_W-1:0] cnt_q, settle_q;
  logic                pass_q, tv_q, len_q, hit_q, conn_q, pass_ok;

  always_comb begin
    case (type_q)
      CONN_RGB: pass_ok = len_q ? (|closed_i) : (&closed_i);
      CONN_LC:  pass_ok = len_q ? (closed_i[0] | closed_i[1]) : (closed_i[0] & closed_i[1]);
      default:  pass_ok = closed_i[0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      type_q   <= CONN_RGB;
      cnt_q    <= '0;
      settle_q <= '0;
      pass_q   <= 1'b0;
      tv_q     <= 1'b0;
      len_q    <= 1'b0;
      hit_q    <= 1'b0;
      conn_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          type_q   <= conn_e'(type_i);
          tv_q     <= (conn_e'(type_i) != CONN_RGB);
          len_q    <= lenient_i;
          settle_q <= settle_i;
          cnt_q    <= settle_i;
          pass_q   <= 1'b0;
          hit_q    <= 1'b0;
          st_q     <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (cnt_q == '0) st_q <= ST_SAMPLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_SAMPLE: begin
          hit_q <= hit_q | pass_ok;
          if (tv_q && !pass_q) begin
            pass_q <= 1'b1;
            cnt_q  <= settle_q;
            st_q   <= ST_SETTLE;
          end else begin
            conn_q <= hit_q | pass_ok;
            st_q   <= ST_DONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sample_o    = (st_q == ST_SAMPLE);
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign connected_o = conn_q;
  assign tv_o        = tv_q;
  assign nib_o       = (tv_q && (st_q == ST_SETTLE || st_q == ST_SAMPLE))
                       ? (pass_q ? NIB_PASS1 : NIB_PASS0) : reg_nib_i;
endmodule

// File: rtl/ld_detect.sv
module ld_detect
  import ld_pkg::*;
#(
  parameter int          SETTLE_W  = 8,
  parameter logic [31:0] TDATA_RST = 32'h9405_0140
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [1:0]           addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic                 start_i,
  input  logic [1:0]           conn_type_i,
  input  logic                 lenient_i,
  input  logic [SETTLE_W-1:0]  settle_i,
  input  logic [NCH*LVL_W-1:0] sense_i,
  output logic [3:0]           mode_nibble_o,
  output logic                 test_en_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 connected_o
);
  logic [NCH*LVL_W-1:0] thr;
  logic [NCH-1:0]       closed;
  logic [3:0]           out_nib;
  logic                 sample, seq_tv;

  ld_regs #(.TDATA_RST(TDATA_RST)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .sample_i (sample),
    .closed_i (closed),
    .rdata_o,
    .thr_o    (thr),
    .test_en_o,
    .out_nib_o(out_nib)
  );

  ld_compare i_cmp (
    .en_i    (test_en_o),
    .sense_i,
    .thr_i   (thr),
    .closed_o(closed)
  );

  ld_seq #(.SETTLE_W(SETTLE_W)) i_seq (
    .clk_i, .rst_ni, .start_i,
    .type_i     (conn_type_i),
    .lenient_i,
    .settle_i,
    .closed_i   (closed),
    .reg_nib_i  (out_nib),
    .sample_o   (sample),
    .busy_o,
    .done_o,
    .connected_o,
    .tv_o       (seq_tv),
    .nib_o      (mode_nibble_o)
  );
endmodule

// File: rtl/ld_detect_chk.sv
module ld_detect_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        connected_o,
  input logic        test_en_o,
  input logic [3:0]  mode_nibble_o,
  input logic [3:0]  reg_nib,
  input logic        tv_run,
  input logic [1:0]  addr_i,
  input logic [31:0] rdata_o
);
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  p_restart_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o);

  p_nib_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o || !tv_run || done_o) |-> (mode_nibble_o == reg_nib));

  p_tv_nib_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tv_run && !done_o) |-> (mode_nibble_o == 4'd3 || mode_nibble_o == 4'd7));

  p_en_verdict_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !test_en_o) |-> !connected_o);

  p_and_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd1) |-> (rdata_o[28] == &rdata_o[31:29]));
endmodule

bind ld_detect ld_detect_chk i_chk (
  .clk_i, .rst_ni, .start_i, .busy_o, .done_o, .connected_o, .test_en_o,
  .mode_nibble_o,
  .reg_nib (out_nib),
  .tv_run  (seq_tv),
  .addr_i, .rdata_o
);

// File: tb/test_ld_detect.sv
module test_ld_detect;
  localparam int SW = 8;

  typedef struct packed {
    bit        conn;
    bit [3:0]  res;
    int        lat;
    bit [15:0] mask;
    int        start_cyc;
    bit [3:0]  regnib;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, start = 0, lenient = 0;
  logic [1:0]  addr = 2'd1, ctype = 0;
  logic [31:0] wdata = 0, rdata;
  logic [SW-1:0] settle = 0;
  logic [29:0] sense;
  logic [3:0]  nib;
  logic        test_en, busy, done, connected;

  bit       ld [3];
  bit [3:0] nd [3];
  bit [9:0] lo [3];
  bit [31:0] tdata_v = 32'h9405_0140, outreg_v = 0;

  int cyc = 0, checks = 0, errors = 0, extra_done = 0;
  bit [15:0] seen = 0;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  ld_detect #(.SETTLE_W(SW)) i_ld_detect (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .start_i(start), .conn_type_i(ctype), .lenient_i(lenient),
    .settle_i(settle), .sense_i(sense), .mode_nibble_o(nib), .test_en_o(test_en),
    .busy_o(busy), .done_o(done), .connected_o(connected)
  );

  // load model: a loaded loop sinks only under its required mode value (0 = any)
  always_comb begin
    for (int i = 0; i < 3; i++)
      sense[i*10 +: 10] = (ld[i] && (nd[i] == 0 || nd[i] == nib)) ? lo[i] : 10'h3FF;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit [4:0] model(input bit [1:0] typ, input bit len);
    bit conn, ok;
    bit [2:0] c;
    bit [3:0] nb;
    int np;
    conn = 0; c = 0; ok = 0;
    np = (typ == 0) ? 1 : 2;
    for (int p = 0; p < np; p++) begin
      nb = (typ == 0) ? outreg_v[7:4] : ((p == 0) ? 4'd3 : 4'd7);
      for (int i = 0; i < 3; i++)
        c[i] = tdata_v[31] && ld[i] && (nd[i] == 0 || nd[i] == nb) && (lo[i] < tdata_v[i*10 +: 10]);
      case (typ)
        2'd0:    ok = len ? |c : &c;
        2'd1:    ok = len ? (c[0] | c[1]) : (c[0] & c[1]);
        default: ok = c[0];
      endcase
      conn |= ok;
    end
    return {conn, c, &c};
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; addr = 2'd1;
    if (a == 2'd0) tdata_v = d;
    if (a == 2'd2) outreg_v = d;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(rdata === exp, tag, rdata, exp);
    addr = 2'd1;
  endtask

  task automatic set_loads(input bit l2, input bit l1, input bit l0);
    ld[0] = l0; ld[1] = l1; ld[2] = l2;
  endtask

  task automatic run_det(input bit [1:0] typ, input bit len, input int s, input bit extra);
    exp_t it;
    bit [4:0] m;
    m = model(typ, len);
    it.conn   = m[4];
    it.res    = m[3:0];
    it.lat    = (typ == 0) ? s + 3 : 2*s + 5;
    it.mask   = (typ == 0) ? (16'd1 << outreg_v[7:4]) : 16'h0088;
    it.regnib = outreg_v[7:4];
    @(negedge clk);
    ctype = typ; lenient = len; settle = SW'(s); start = 1;
    it.start_cyc = cyc;
    q.push_back(it);
    @(negedge clk);
    start = 0;
    if (extra) begin
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    exp_t it;
    if (rst_n) begin
      if (busy && !done) seen |= (16'd1 << nib);
      if (done) begin
        if (q.size() == 0) extra_done++;
        else begin
          it = q.pop_front();
          chk(connected == it.conn, "R7/R8/R9 verdict", 32'(connected), 32'(it.conn));
          chk(rdata[31:28] == it.res, "R3/R4 result bits", 32'(rdata[31:28]), 32'(it.res));
          chk((cyc - it.start_cyc) == it.lat, "R11 latency", cyc - it.start_cyc, it.lat);
          chk(seen == it.mask, "R9/R10 mode values seen", 32'(seen), 32'(it.mask));
          chk(nib == it.regnib, "R10 mode restored", 32'(nib), 32'(it.regnib));
        end
        seen = 0;
      end
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin ld[i] = 0; nd[i] = 0; lo[i] = 10'h050; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 R2 reset state
    chk(test_en == 1'b1, "R2 test_en", 32'(test_en), 1);
    chk({busy, done, connected} == 3'b000, "R1 status", 32'({busy, done, connected}), 0);
    bus_rd(2'd0, 32'h9405_0140, "R1 test-data");
    bus_rd(2'd1, 32'h0, "R1 test-control");
    bus_rd(2'd2, 32'h0, "R1 output");
    // R5 result bits not writable
    bus_wr(2'd1, 32'hFFFF_FFFF);
    bus_rd(2'd1, 32'h0FFF_FFFF, "R5 control bits");
    bus_wr(2'd1, 32'h0);
    bus_wr(2'd2, 32'h0000_0050);
    // R7 RGB
    set_loads(1, 1, 1);
    run_det(2'd0, 0, 3, 0);
    set_loads(0, 1, 0);
    run_det(2'd0, 0, 0, 0);
    run_det(2'd0, 1, 10, 0);
    // R2 R3 threshold layout and equality boundary
    bus_wr(2'd0, {1'b1, 1'b0, 10'h080, 10'h200, 10'h100});
    set_loads(1, 1, 1);
    lo[0] = 10'h0FF; lo[1] = 10'h200; lo[2] = 10'h07F;
    run_det(2'd0, 1, 2, 0);
    run_det(2'd0, 0, 2, 0);
    bus_wr(2'd0, 32'h9405_0140);
    for (int i = 0; i < 3; i++) lo[i] = 10'h050;
    // R8 luma/chroma and composite
    set_loads(0, 1, 1);
    run_det(2'd1, 0, 1, 0);
    set_loads(0, 0, 1);
    run_det(2'd1, 0, 1, 0);
    run_det(2'd1, 1, 1, 0);
    set_loads(1, 0, 0);
    run_det(2'd1, 1, 1, 0);
    run_det(2'd2, 1, 1, 0);
    // R9 two-pass retest
    set_loads(0, 0, 1);
    nd[0] = 4'd7; run_det(2'd2, 0, 2, 0);
    nd[0] = 4'd3; run_det(2'd2, 0, 2, 0);
    nd[0] = 4'd5; run_det(2'd2, 0, 2, 0);
    nd[0] = 4'd0; run_det(2'd3, 0, 0, 0);
    // R12 restart while busy
    set_loads(1, 1, 1);
    run_det(2'd0, 0, 6, 1);
    repeat (30) @(negedge clk);
    chk(extra_done == 0, "R12 extra done", extra_done, 0);
    // R6 disabled testing
    bus_wr(2'd0, 32'h1405_0140);
    chk(test_en == 1'b0, "R6 test_en", 32'(test_en), 0);
    run_det(2'd0, 1, 2, 0);
    run_det(2'd2, 1, 2, 0);
    bus_rd(2'd1, 32'h0, "R6 results masked");
    bus_rd(2'd2, 32'h0000_0050, "R10 output register kept");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R11 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule